// File: doc/BRIEF.md
# PCI Reset and Strap Mode Controller

This block decides, once per chip reset, how the device behaves on a PCI bus, and then manages the bus reset line to match. Four configuration straps are sampled while the chip's internal reset is held and frozen when it ends. The straps select central-function operation, ownership of bus arbitration by the on-chip arbiter, PCI host operation and boot from a PROM. The frozen combination is checked against a dependency rule. An unsupported combination raises a status flag, and the block then falls back to the plain peripheral configuration.

In central-function mode the block drives the active-low PCI bus reset low from power-on. It keeps the line low until software writes 1 to a release bit, and it drives it low again if software writes 0. In peripheral (non-central) mode the block never enables the pad driver. It instead synchronises the incoming PCI reset pin and presents it as a chip reset request. All outputs are registered.

Top module: `pci_strap_rst_ctrl`

## Requirements
- R1: The straps are loaded on every clock edge while `rst` is 1. The value present at the last edge with `rst` high is held until the next reset, and later changes on the strap inputs have no effect on any output.
- R2: `strap_illegal` is 1 exactly when the held straps have central=0 with arbiter=1 or host=1, or have central=1 with PROM boot=0. With central, arbiter and host all 0, either PROM boot value is legal.
- R3: When `strap_illegal` is 1, `mode_central`, `mode_arb_int` and `mode_host` are all 0.
- R4: For a legal combination, `mode_central`, `mode_arb_int` and `mode_host` equal the held central, arbiter and host strap values, valid from the first edge after reset ends.
- R5: In central-function mode, `pcirst_oe` is 1 and `pcirst_n_out` is 0 after reset, and both stay so until a release write.
- R6: In central-function mode, a cycle with `sw_wr`=1 loads `sw_release` into the release bit. `pcirst_n_out` equals that bit two edges after the write edge, so writing 1 releases the bus reset and writing 0 asserts it again.
- R7: Outside central-function mode, `pcirst_oe` stays 0 and `pcirst_n_out` stays 1, and release writes have no effect.
- R8: Outside central-function mode, `chip_rst_req` equals the inverse of `pcirst_n_in` delayed by SYNC_STAGES+1 edges. In central-function mode `chip_rst_req` stays 0 whatever the pin does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high chip reset; straps are sampled while high |
| strap_central | input | 1 | Central-function enable strap |
| strap_arb | input | 1 | On-chip arbiter select strap |
| strap_host | input | 1 | PCI host select strap |
| strap_prom | input | 1 | PROM boot select strap |
| sw_wr | input | 1 | Write strobe for the release bit |
| sw_release | input | 1 | Release bit data (1 = release bus reset) |
| pcirst_n_in | input | 1 | PCI reset pad input (active low) |
| pcirst_n_out | output | 1 | PCI reset pad output value (active low) |
| pcirst_oe | output | 1 | PCI reset pad output enable |
| chip_rst_req | output | 1 | Chip reset request taken from the PCI reset pin |
| mode_central | output | 1 | Central-function mode active |
| mode_arb_int | output | 1 | On-chip arbiter owns the bus |
| mode_host | output | 1 | PCI host mode active |
| strap_illegal | output | 1 | Held strap combination is unsupported |

## Verification
All sixteen strap combinations are applied, because a design with a wrong dependency rule would flag the central/PROM=0 case or the all-zero/PROM=1 case the wrong way. It could also leave host or arbiter mode active under an unsupported setting. Straps are changed after reset to catch a latch that keeps sampling. A release write in peripheral mode would show up as a driven pad. The pin is toggled in both modes to catch a pass-through that ignores the mode, and to catch a wrong synchroniser depth. A write of 0 after release checks that the bus reset can be asserted again.

// File: rtl/pci_strap_pkg.sv
package pci_strap_pkg;

  typedef struct packed {
    logic central;
    logic arb;
    logic host;
    logic prom;
  } strap_t;

  typedef struct packed {
    logic central;
    logic arb_int;
    logic host;
    logic illegal;
  } mode_t;

  // Host and arbiter need central function; central function needs PROM boot.
  function automatic logic strap_ok(strap_t s);
    if (s.central) return s.prom;
    return !(s.arb | s.host);
  endfunction

  function automatic mode_t strap_decode(strap_t s);
    mode_t m;
    logic ok;
    ok        = strap_ok(s);
    m.central = ok & s.central;
    m.arb_int = ok & s.arb;
    m.host    = ok & s.host;
    m.illegal = !ok;
    return m;
  endfunction

endpackage

// File: rtl/pci_strap_latch.sv
module pci_strap_latch
  import pci_strap_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  strap_t strap_in,
  output strap_t strap_q,
  output mode_t  mode_q
);

  // Load every cycle of reset; the last reset edge wins, then freeze.
  always_ff @(posedge clk) begin
    if (rst) begin
      strap_q <= strap_in;
      mode_q  <= strap_decode(strap_in);
    end
  end

  // R1: held straps never move outside reset
  a_r1_frozen: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(strap_q) && $stable(mode_q)));

  // R3: fallback configuration on unsupported straps
  a_r3_fallback: assert property (@(posedge clk) disable iff (rst)
    mode_q.illegal |-> !(mode_q.central | mode_q.arb_int | mode_q.host));

  // R2: host or arbiter without central function is never reported as valid
  a_r2_dep: assert property (@(posedge clk) disable iff (rst)
    (mode_q.host | mode_q.arb_int) |-> (mode_q.central && strap_q.prom));

endmodule

// File: rtl/pci_pin_sync.sv
module pci_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din_n,
  output logic dout_n
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= din_n;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[LAST-1:0], din_n};
      end
    end
  endgenerate

  assign dout_n = chain[LAST];

endmodule

// File: rtl/pci_rst_seq.sv
module pci_rst_seq (
  input  logic clk,
  input  logic rst,
  input  logic central,
  input  logic sw_wr,
  input  logic sw_release,
  input  logic pin_sync_n,
  output logic pcirst_n_out,
  output logic pcirst_oe,
  output logic chip_rst_req
);

  logic rel_q;

  // Release bit: only writable when the block owns the bus reset.
  always_ff @(posedge clk) begin
    if (rst)                   rel_q <= 1'b0;
    else if (sw_wr && central) rel_q <= sw_release;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcirst_oe    <= central;
      pcirst_n_out <= !central;
      chip_rst_req <= 1'b0;
    end else begin
      pcirst_oe    <= central;
      pcirst_n_out <= central ? rel_q : 1'b1;
      chip_rst_req <= !central && !pin_sync_n;
    end
  end

  // R7: pad driver enabled only in central-function mode
  a_r7_oe_central: assert property (@(posedge clk) disable iff (rst)
    pcirst_oe |-> central);

  // R7: no low level on the pad value outside central-function mode
  a_r7_out_idle: assert property (@(posedge clk) disable iff (rst)
    (!central && !$past(rst)) |-> pcirst_n_out);

  // R8: pin pass-through silent in central-function mode
  a_r8_no_req_central: assert property (@(posedge clk) disable iff (rst)
    chip_rst_req |-> !central);

  // R6: clearing the release bit drives the bus reset low next edge
  a_r6_reassert: assert property (@(posedge clk) disable iff (rst)
    $fell(rel_q) |=> !pcirst_n_out);

  // R6: setting the release bit lets the bus reset go high next edge
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    $rose(rel_q) |=> pcirst_n_out);

endmodule

// File: rtl/pci_strap_rst_ctrl.sv
module pci_strap_rst_ctrl
  import pci_strap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strap_central,
  input  logic strap_arb,
  input  logic strap_host,
  input  logic strap_prom,
  input  logic sw_wr,
  input  logic sw_release,
  input  logic pcirst_n_in,
  output logic pcirst_n_out,
  output logic pcirst_oe,
  output logic chip_rst_req,
  output logic mode_central,
  output logic mode_arb_int,
  output logic mode_host,
  output logic strap_illegal
);

  strap_t strap_in;
  strap_t strap_q;
  mode_t  mode_q;
  logic   pin_sync_n;

  assign strap_in = '{central: strap_central, arb: strap_arb,
                      host: strap_host, prom: strap_prom};

  pci_strap_latch u_latch (
    .clk      (clk),
    .rst      (rst),
    .strap_in (strap_in),
    .strap_q  (strap_q),
    .mode_q   (mode_q)
  );

  pci_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .din_n  (pcirst_n_in),
    .dout_n (pin_sync_n)
  );

  pci_rst_seq u_seq (
    .clk          (clk),
    .rst          (rst),
    .central      (mode_q.central),
    .sw_wr        (sw_wr),
    .sw_release   (sw_release),
    .pin_sync_n   (pin_sync_n),
    .pcirst_n_out (pcirst_n_out),
    .pcirst_oe    (pcirst_oe),
    .chip_rst_req (chip_rst_req)
  );

  assign mode_central  = mode_q.central;
  assign mode_arb_int  = mode_q.arb_int;
  assign mode_host     = mode_q.host;
  assign strap_illegal = mode_q.illegal;

  // R4: a legal setting reports the held strap values unchanged
  a_r4_legal_map: assert property (@(posedge clk) disable iff (rst)
    !strap_illegal |-> (mode_central == strap_q.central &&
                        mode_arb_int == strap_q.arb &&
                        mode_host == strap_q.host));

endmodule

// File: tb/pci_strap_rst_ctrl_bench.sv
`timescale 1ns/1ps
module pci_strap_rst_ctrl_bench;

  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_c = 1'b0, s_a = 1'b0, s_h = 1'b0, s_p = 1'b0;
  logic sw_wr = 1'b0, sw_release = 1'b0;
  logic pin_n = 1'b1;
  logic pcirst_n_out, pcirst_oe, chip_rst_req;
  logic mode_central, mode_arb_int, mode_host, strap_illegal;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pci_strap_rst_ctrl #(.SYNC_STAGES(SYNC)) u_pci_strap_rst_ctrl (
    .clk(clk), .rst(rst),
    .strap_central(s_c), .strap_arb(s_a), .strap_host(s_h), .strap_prom(s_p),
    .sw_wr(sw_wr), .sw_release(sw_release), .pcirst_n_in(pin_n),
    .pcirst_n_out(pcirst_n_out), .pcirst_oe(pcirst_oe),
    .chip_rst_req(chip_rst_req), .mode_central(mode_central),
    .mode_arb_int(mode_arb_int), .mode_host(mode_host),
    .strap_illegal(strap_illegal)
  );

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Reset with given straps; returns at a negedge one edge after release.
  task automatic reset_with(logic c, logic a, logic h, logic p);
    @(negedge clk);
    rst = 1'b1; s_c = c; s_a = a; s_h = h; s_p = p;
    sw_wr = 1'b0; pin_n = 1'b1;
    step(3);
    rst = 1'b0;
    step(1);
  endtask

  task automatic write_rel(logic v);
    sw_wr = 1'b1; sw_release = v;
    step(1);
    sw_wr = 1'b0;
  endtask

  // R2 R3 R4: sweep all strap combinations
  task automatic t_all_combos();
    for (int i = 0; i < 16; i++) begin
      logic c, a, h, p, bad;
      {c, a, h, p} = 4'(i);
      bad = (c == 1'b0 && (a || h)) || (c == 1'b1 && p == 1'b0);
      reset_with(c, a, h, p);
      check("R2", $sformatf("illegal combo %0d", i), strap_illegal, bad);
      check(bad ? "R3" : "R4", $sformatf("central combo %0d", i), mode_central, bad ? 1'b0 : c);
      check(bad ? "R3" : "R4", $sformatf("arb combo %0d", i), mode_arb_int, bad ? 1'b0 : a);
      check(bad ? "R3" : "R4", $sformatf("host combo %0d", i), mode_host, bad ? 1'b0 : h);
      check((!bad && c) ? "R5" : "R7", $sformatf("oe combo %0d", i), pcirst_oe, !bad && c);
    end
  endtask

  // R1: straps ignored once reset ends
  task automatic t_frozen();
    reset_with(1'b0, 1'b0, 1'b0, 1'b0);
    s_c = 1'b1; s_a = 1'b1; s_h = 1'b1; s_p = 1'b0;
    step(3);
    check("R1", "central after strap change", mode_central, 1'b0);
    check("R1", "host after strap change", mode_host, 1'b0);
    check("R1", "illegal after strap change", strap_illegal, 1'b0);
    check("R1", "oe after strap change", pcirst_oe, 1'b0);
  endtask

  // R5 R6: bus reset held, released, re-asserted by software
  task automatic t_central_release();
    reset_with(1'b1, 1'b1, 1'b1, 1'b1);
    check("R5", "bus reset low after reset", pcirst_n_out, 1'b0);
    step(10);
    check("R5", "bus reset still low", pcirst_n_out, 1'b0);
    check("R5", "oe held", pcirst_oe, 1'b1);
    write_rel(1'b1);
    check("R6", "one edge after write no change yet", pcirst_n_out, 1'b0);
    step(1);
    check("R6", "released two edges after write", pcirst_n_out, 1'b1);
    write_rel(1'b0);
    step(1);
    check("R6", "re-asserted by write 0", pcirst_n_out, 1'b0);
    check("R6", "oe stays on", pcirst_oe, 1'b1);
  endtask

  // R7: release writes ignored in peripheral mode
  task automatic t_periph_write();
    reset_with(1'b0, 1'b0, 1'b0, 1'b1);
    write_rel(1'b1);
    step(2);
    check("R7", "oe off after write", pcirst_oe, 1'b0);
    check("R7", "pad value high after write", pcirst_n_out, 1'b1);
  endtask

  // R8: pin pass-through latency and mode gating
  task automatic t_pin_pass();
    reset_with(1'b0, 1'b0, 1'b0, 1'b0);
    pin_n = 1'b0;
    step(SYNC);
    check("R8", "request not before latency", chip_rst_req, 1'b0);
    step(1);
    check("R8", "request after latency", chip_rst_req, 1'b1);
    pin_n = 1'b1;
    step(SYNC + 1);
    check("R8", "request drops with pin", chip_rst_req, 1'b0);
    reset_with(1'b1, 1'b0, 1'b0, 1'b1);
    pin_n = 1'b0;
    step(SYNC + 3);
    check("R8", "no request in central mode", chip_rst_req, 1'b0);
    pin_n = 1'b1;
  endtask

  initial begin
    step(1);
    check("R5", "oe during reset with zero straps", pcirst_oe, 1'b0);
    t_all_combos();
    t_frozen();
    t_central_release();
    t_periph_write();
    t_pin_pass();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule